// File: doc/BRIEF.md
# Programmable Conversion Sequencer

This block drives an external analog-to-digital converter through a programmable list of up to eight conversions. A host fills eight control slots. Each slot is one byte that holds an enable flag, a resolution code, a reference range and an input channel. When a cycle starts, the sequencer walks the slots from the lowest index upward. It skips every disabled slot in the same clock cycle in which it is reached, and issues one start pulse to the converter for each enabled slot. Each result that comes back is written into the result register that belongs to the slot. A one-cycle pulse marks the end of the cycle.

There are two ways to start cycles. In continuous operation, a new cycle starts by itself one clock after the previous one ends. In sampled operation, exactly one cycle runs for each trigger pulse. A timeout counter is loaded for every conversion. Its limit is derived from the resolution of the slot, because conversion time doubles with each extra bit. If the converter stays silent past that limit, the block raises an error pulse, keeps the old result, and goes on to the next slot. A strobe tells downstream accumulation logic when a fresh slot-0 (current) result has been stored.

Top module: `conv_seq`

## Requirements
- R1: After reset, every control slot and every result register reads as zero, and all output pulses (converter start, cycle done, current valid, timeout) are low.
- R2: A control byte is decoded as bit 7 enable, bits 6-4 resolution code, bit 3 reference select (0 = narrow ±170 mV range, 1 = wide ±340 mV range) and bits 2-0 input channel. The start pulse presents the channel, reference and resolution code of the slot being converted.
- R3: Within a cycle, enabled slots are converted in ascending index order, each exactly once, and no disabled slot is ever started. The first start appears one clock after the trigger is sampled.
- R4: The 16-bit result returned with the done pulse (bit 15 sign, bits 14-0 magnitude) is stored verbatim in the result register of the slot that was converted. It reads back at host address 8 + slot.
- R5: Exactly one one-cycle cycle-done pulse is produced per cycle. It never coincides with a converter start.
- R6: When no slot is enabled, a started cycle produces its cycle-done pulse in the clock after the trigger and issues no start.
- R7: The timeout limit for a conversion is SCALE × 2^(9 + code) + MARGIN clocks. If no done arrives, the timeout pulse appears limit + 1 clocks after the start pulse. It is never raised in a clock that follows a done. The result register keeps its old value, and the next enabled slot is started.
- R8: A one-cycle current-valid pulse follows the storing of a slot-0 result, once per cycle. It is absent when slot 0 is disabled.
- R9: With continuous mode held high, a new cycle starts one clock after each cycle-done pulse. In sampled mode, a trigger that arrives while a cycle is running is ignored, and no further starts follow the cycle-done pulse.
- R10: Host writes to result addresses (8-15) have no effect. Control slots read back in bits 7-0, with bits 15-8 zero.
- R11: At most one conversion is outstanding. A new start follows only after the previous done or timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 4 | Host address: 0-7 control slots, 8-15 result registers |
| host_wdata | input | 8 | Host write data (control byte) |
| host_rdata | output | 16 | Host read data, combinational on host_addr |
| run_cont | input | 1 | Continuous mode: repeat cycles back to back |
| sample_trig | input | 1 | Starts one cycle when the sequencer is idle |
| cv_start | output | 1 | One-cycle conversion start pulse |
| cv_chan | output | 3 | Input channel of the conversion |
| cv_ref | output | 1 | Reference range select of the conversion |
| cv_res | output | 3 | Resolution code of the conversion |
| cv_done | input | 1 | Converter done pulse |
| cv_result | input | 16 | Sign/magnitude result, valid with cv_done |
| cycle_done | output | 1 | One-cycle end-of-cycle pulse |
| cur_valid | output | 1 | One-cycle pulse after a slot-0 result is stored |
| tmo_err | output | 1 | One-cycle conversion timeout pulse |

## Verification
The bench builds the sequencer with SCALE = 1 and MARGIN = 8. With these values the timeout limit at the lowest resolution code is 520 clocks, so the exact clock of the timeout pulse can be measured within a short run. At default values the same case would take over two thousand clocks for each attempt. The converter model answers within two to four clocks and keeps every value it returned. This lets the bench test slot ordering, skip patterns, continuous restarts and result storage across many distinct enable masks.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    localparam int RES_W  = 3;
    localparam int MUX_W  = 3;
    localparam int CTRL_W = 1 + RES_W + 1 + MUX_W;

    typedef struct packed {
        logic             en;
        logic [RES_W-1:0] res;
        logic             ref_hi;
        logic [MUX_W-1:0] mux;
    } slot_ctrl_t;

    typedef enum logic {
        ST_IDLE,
        ST_WAIT
    } seq_state_t;

endpackage

// File: rtl/conv_seq_regs.sv
module conv_seq_regs
    import conv_seq_pkg::*;
#(
    parameter int NSLOT = 8,
    parameter int DW    = 16,
    localparam int IW   = $clog2(NSLOT)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_we,
    input  logic [IW:0]             host_addr,
    input  logic [CTRL_W-1:0]       host_wdata,
    output logic [DW-1:0]           host_rdata,
    output logic [NSLOT*CTRL_W-1:0] ctrl_flat,
    input  logic                    res_we,
    input  logic [IW-1:0]           res_idx,
    input  logic [DW-1:0]           res_data
);

    logic [CTRL_W-1:0] ctrl_d [NSLOT];
    logic [CTRL_W-1:0] ctrl_q [NSLOT];
    logic [DW-1:0]     res_d  [NSLOT];
    logic [DW-1:0]     res_q  [NSLOT];

    always_comb begin
        ctrl_d = ctrl_q;
        res_d  = res_q;
        if (host_we && !host_addr[IW]) begin
            ctrl_d[host_addr[IW-1:0]] = host_wdata;
        end
        if (res_we) begin
            res_d[res_idx] = res_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) begin
                ctrl_q[i] <= '0;
                res_q[i]  <= '0;
            end
        end else begin
            ctrl_q <= ctrl_d;
            res_q  <= res_d;
        end
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_flat
        assign ctrl_flat[g*CTRL_W +: CTRL_W] = ctrl_q[g];
    end

    assign host_rdata = host_addr[IW] ? res_q[host_addr[IW-1:0]]
                                      : DW'(ctrl_q[host_addr[IW-1:0]]);

endmodule

// File: rtl/conv_seq_timer.sv
module conv_seq_timer #(
    parameter int TW = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] limit,
    output logic          expired
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load) begin
            cnt_d = limit;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/conv_seq_fsm.sv
module conv_seq_fsm
    import conv_seq_pkg::*;
#(
    parameter int NSLOT   = 8,
    parameter int MIN_RES = 9,
    parameter int SCALE   = 4,
    parameter int MARGIN  = 64,
    parameter int TW      = 19,
    localparam int IW     = $clog2(NSLOT),
    localparam int IW1    = IW + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run_cont,
    input  logic                    sample_trig,
    input  logic                    cv_done,
    input  logic                    tmr_expired,
    input  logic [NSLOT*CTRL_W-1:0] ctrl_flat,
    output logic                    cv_start,
    output logic [MUX_W-1:0]        cv_chan,
    output logic                    cv_ref,
    output logic [RES_W-1:0]        cv_res,
    output logic                    res_we,
    output logic [IW-1:0]           res_idx,
    output logic                    tmr_load,
    output logic [TW-1:0]           tmr_limit,
    output logic                    cycle_done,
    output logic                    cur_valid,
    output logic                    tmo_err
);

    typedef struct packed {
        seq_state_t       st;
        logic [IW-1:0]    idx;
        logic             start;
        logic [MUX_W-1:0] chan;
        logic             ref_hi;
        logic [RES_W-1:0] res;
        logic             cdone;
        logic             cvalid;
        logic             tmo;
    } fsm_t;

    fsm_t          d, q;
    slot_ctrl_t    slot [NSLOT];
    logic [IW1-1:0] base;
    logic [IW-1:0] nxt;
    logic          found;
    logic          launch;
    logic          advance;
    int            sh;

    always_comb begin
        for (int i = 0; i < NSLOT; i++) begin
            slot[i] = slot_ctrl_t'(ctrl_flat[i*CTRL_W +: CTRL_W]);
        end

        // lowest enabled slot at or above the search base
        base  = (q.st == ST_IDLE) ? '0 : ({1'b0, q.idx} + 1'b1);
        found = 1'b0;
        nxt   = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (slot[i].en && (IW1'(i) >= base)) begin
                found = 1'b1;
                nxt   = IW'(i);
            end
        end

        d        = q;
        d.start  = 1'b0;
        d.cdone  = 1'b0;
        d.cvalid = 1'b0;
        d.tmo    = 1'b0;
        res_we   = 1'b0;
        launch   = 1'b0;
        advance  = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (run_cont || sample_trig) begin
                    if (found) launch  = 1'b1;
                    else       d.cdone = 1'b1;
                end
            end
            ST_WAIT: begin
                if (cv_done) begin
                    res_we   = 1'b1;
                    d.cvalid = (q.idx == '0);
                    advance  = 1'b1;
                end else if (tmr_expired) begin
                    d.tmo   = 1'b1;
                    advance = 1'b1;
                end
                if (advance) begin
                    if (found) begin
                        launch = 1'b1;
                    end else begin
                        d.st    = ST_IDLE;
                        d.cdone = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (launch) begin
            d.st     = ST_WAIT;
            d.idx    = nxt;
            d.start  = 1'b1;
            d.chan   = slot[nxt].mux;
            d.ref_hi = slot[nxt].ref_hi;
            d.res    = slot[nxt].res;
        end

        sh        = MIN_RES + int'(slot[nxt].res);
        tmr_limit = (TW'(SCALE) << sh) + TW'(MARGIN);
        tmr_load  = launch;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign cv_start   = q.start;
    assign cv_chan    = q.chan;
    assign cv_ref     = q.ref_hi;
    assign cv_res     = q.res;
    assign res_idx    = q.idx;
    assign cycle_done = q.cdone;
    assign cur_valid  = q.cvalid;
    assign tmo_err    = q.tmo;

endmodule

// File: rtl/conv_seq.sv
module conv_seq
    import conv_seq_pkg::*;
#(
    parameter int NSLOT   = 8,
    parameter int DW      = 16,
    parameter int MIN_RES = 9,
    parameter int SCALE   = 4,
    parameter int MARGIN  = 64,
    localparam int IW     = $clog2(NSLOT),
    localparam int TW     = $clog2(SCALE * (2 ** (MIN_RES + (2 ** RES_W) - 1)) + MARGIN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [IW:0]       host_addr,
    input  logic [CTRL_W-1:0] host_wdata,
    output logic [DW-1:0]     host_rdata,
    input  logic              run_cont,
    input  logic              sample_trig,
    output logic              cv_start,
    output logic [MUX_W-1:0]  cv_chan,
    output logic              cv_ref,
    output logic [RES_W-1:0]  cv_res,
    input  logic              cv_done,
    input  logic [DW-1:0]     cv_result,
    output logic              cycle_done,
    output logic              cur_valid,
    output logic              tmo_err
);

    logic [NSLOT*CTRL_W-1:0] ctrl_flat;
    logic                    res_we;
    logic [IW-1:0]           res_idx;
    logic                    tmr_load;
    logic [TW-1:0]           tmr_limit;
    logic                    tmr_expired;

    conv_seq_regs #(.NSLOT(NSLOT), .DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .ctrl_flat  (ctrl_flat),
        .res_we     (res_we),
        .res_idx    (res_idx),
        .res_data   (cv_result)
    );

    conv_seq_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .limit   (tmr_limit),
        .expired (tmr_expired)
    );

    conv_seq_fsm #(
        .NSLOT   (NSLOT),
        .MIN_RES (MIN_RES),
        .SCALE   (SCALE),
        .MARGIN  (MARGIN),
        .TW      (TW)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_cont    (run_cont),
        .sample_trig (sample_trig),
        .cv_done     (cv_done),
        .tmr_expired (tmr_expired),
        .ctrl_flat   (ctrl_flat),
        .cv_start    (cv_start),
        .cv_chan     (cv_chan),
        .cv_ref      (cv_ref),
        .cv_res      (cv_res),
        .res_we      (res_we),
        .res_idx     (res_idx),
        .tmr_load    (tmr_load),
        .tmr_limit   (tmr_limit),
        .cycle_done  (cycle_done),
        .cur_valid   (cur_valid),
        .tmo_err     (tmo_err)
    );

endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cv_start,
    input logic cv_done,
    input logic cycle_done,
    input logic cur_valid,
    input logic tmo_err
);

    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                  pend_q <= 1'b0;
        else if (cv_start)           pend_q <= 1'b1;
        else if (cv_done || tmo_err) pend_q <= 1'b0;
    end

    assert_no_done_with_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> !cv_start);

    assert_valid_follows_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cur_valid |-> $past(cv_done));

    assert_tmo_not_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_err |-> !$past(cv_done));

    assert_tmo_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_err |=> !tmo_err);

    assert_single_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cv_start |-> (!pend_q || tmo_err));

endmodule

bind conv_seq conv_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cv_start   (cv_start),
    .cv_done    (cv_done),
    .cycle_done (cycle_done),
    .cur_valid  (cur_valid),
    .tmo_err    (tmo_err)
);

// File: tb/sim_conv_seq.sv
`timescale 1ns/1ps
module sim_conv_seq;

    localparam int SCALE  = 1;
    localparam int MARGIN = 8;
    localparam int TMO_L  = SCALE * 512 + MARGIN;

    // {enable mask, expected number of starts}
    localparam logic [11:0] VEC [7] = '{
        {8'hFF, 4'd8}, {8'h01, 4'd1}, {8'h80, 4'd1}, {8'hA5, 4'd4},
        {8'h5A, 4'd4}, {8'h00, 4'd0}, {8'h3C, 4'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [15:0] host_rdata;
    logic        run_cont = 1'b0;
    logic        sample_trig = 1'b0;
    logic        cv_start;
    logic [2:0]  cv_chan;
    logic        cv_ref;
    logic [2:0]  cv_res;
    logic        cv_done = 1'b0;
    logic [15:0] cv_result = '0;
    logic        cycle_done, cur_valid, tmo_err;

    conv_seq #(.SCALE(SCALE), .MARGIN(MARGIN)) u0 (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .run_cont(run_cont),
        .sample_trig(sample_trig), .cv_start(cv_start), .cv_chan(cv_chan),
        .cv_ref(cv_ref), .cv_res(cv_res), .cv_done(cv_done), .cv_result(cv_result),
        .cycle_done(cycle_done), .cur_valid(cur_valid), .tmo_err(tmo_err)
    );

    always #4 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    int starts, dones, valids, tmos;
    int first_start_cyc, tmo_cyc, done_cyc, last_done_cyc, gap, last_slot;
    int pend = 0, nconv = 0;
    logic [2:0]  lchan = '0;
    logic [7:0]  mute = '0;
    logic [7:0]  ctrl_m [8];
    logic [15:0] last_val [8];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        starts = 0; dones = 0; valids = 0; tmos = 0;
        first_start_cyc = -1; tmo_cyc = -1; done_cyc = -1;
        last_done_cyc = -1; gap = -1; last_slot = -1;
    endtask

    task automatic host_write(input logic [3:0] a, input logic [7:0] dat);
        @(negedge clk); #1;
        host_we = 1'b1; host_addr = a; host_wdata = dat;
        @(negedge clk); #1;
        host_we = 1'b0;
    endtask

    task automatic host_read(input logic [3:0] a, output logic [15:0] dat);
        @(negedge clk); #1;
        host_addr = a;
        #1 dat = host_rdata;
    endtask

    task automatic set_slot(input int i, input logic [7:0] b);
        ctrl_m[i] = b;
        host_write(4'(i), b);
    endtask

    task automatic pulse_trig(output int t);
        @(negedge clk); #1;
        sample_trig = 1'b1; t = cyc;
        @(negedge clk); #1;
        sample_trig = 1'b0;
    endtask

    task automatic wait_dones(input int n);
        for (int k = 0; k < 4000 && dones < n; k++) begin
            @(negedge clk); #1;
        end
    endtask

    // converter model and output monitor, one process at the falling edge
    initial begin
        clear_mon();
        for (int i = 0; i < 8; i++) begin ctrl_m[i] = '0; last_val[i] = '0; end
        forever begin
            @(negedge clk);
            cyc++;
            cv_done = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0 && !mute[lchan]) begin
                    nconv++;
                    cv_result = {lchan[0], 15'(int'(lchan) * 1111 + nconv * 7)};
                    last_val[lchan] = cv_result;
                    cv_done = 1'b1;
                end
            end
            if (cv_start) begin
                starts++;
                if (first_start_cyc < 0) first_start_cyc = cyc;
                if (last_done_cyc >= 0 && gap < 0) gap = cyc - last_done_cyc;
                chk(int'(cv_chan) > last_slot, "R3", "slot order", cv_chan, last_slot + 1);
                chk(ctrl_m[cv_chan][7], "R3", "disabled slot started", 0, 1);
                chk(cv_ref == ctrl_m[cv_chan][3], "R2", "reference field", cv_ref, ctrl_m[cv_chan][3]);
                chk(cv_res == ctrl_m[cv_chan][6:4], "R2", "resolution field", cv_res, ctrl_m[cv_chan][6:4]);
                last_slot = int'(cv_chan);
                pend = 2 + (int'(cv_chan) % 3);
                lchan = cv_chan;
            end
            if (cycle_done) begin
                dones++; done_cyc = cyc; last_done_cyc = cyc; last_slot = -1;
            end
            if (cur_valid) valids++;
            if (tmo_err) begin tmos++; tmo_cyc = cyc; end
        end
    end

    initial begin
        #(150000 * 8);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] rd, old;
        logic [7:0]  mask;
        int t;

        repeat (3) @(negedge clk);
        chk(!cv_start && !cycle_done && !cur_valid && !tmo_err, "R1", "outputs in reset", 1, 0);
        #1 rst_n = 1'b1;
        for (int a = 0; a < 16; a++) begin
            host_read(4'(a), rd);
            chk(rd == 16'h0, "R1", "register after reset", rd, 0);
        end

        // table of enable masks, one sampled cycle each
        for (int v = 0; v < 7; v++) begin
            mask = VEC[v][11:4];
            for (int i = 0; i < 8; i++)
                set_slot(i, {mask[i], 3'((i + v) % 8), 1'(i % 2), 3'(i)});
            clear_mon();
            pulse_trig(t);
            wait_dones(1);
            repeat (5) @(negedge clk);
            #1;
            chk(dones == 1, "R5", "cycle done count", dones, 1);
            chk(starts == int'(VEC[v][3:0]), "R3", "start count", starts, VEC[v][3:0]);
            chk(valids == int'(mask[0]), "R8", "current valid count", valids, mask[0]);
            if (mask == 8'h00) begin
                chk(done_cyc - t == 1, "R6", "empty cycle done delay", done_cyc - t, 1);
            end else begin
                chk(first_start_cyc - t == 1, "R3", "first start delay", first_start_cyc - t, 1);
            end
            for (int i = 0; i < 8; i++) begin
                if (mask[i]) begin
                    host_read(4'(8 + i), rd);
                    chk(rd == last_val[i], "R4", "stored result", rd, last_val[i]);
                end
            end
        end

        // timeout on slot 2 (code 0), then slot 5 still converted
        host_read(4'd10, old);
        for (int i = 0; i < 8; i++) set_slot(i, {5'b0, 3'(i)});
        set_slot(2, 8'b1000_0010);
        set_slot(5, 8'b1001_1101);
        mute = 8'h04;
        clear_mon();
        pulse_trig(t);
        wait_dones(1);
        repeat (3) @(negedge clk);
        #1;
        chk(tmos == 1, "R7", "timeout count", tmos, 1);
        chk(tmo_cyc - first_start_cyc == TMO_L + 1, "R7", "timeout delay",
            tmo_cyc - first_start_cyc, TMO_L + 1);
        chk(starts == 2, "R7", "moved on after timeout", starts, 2);
        host_read(4'd10, rd);
        chk(rd == old, "R7", "result kept on timeout", rd, old);
        host_read(4'd13, rd);
        chk(rd == last_val[5], "R7", "next slot result", rd, last_val[5]);
        mute = '0;

        // host writes to result space are ignored; control readback width
        host_read(4'd13, old);
        host_write(4'd13, 8'hEF);
        host_read(4'd13, rd);
        chk(rd == old, "R10", "result write ignored", rd, old);
        ctrl_m[3] = 8'hC5;
        host_write(4'd3, 8'hC5);
        host_read(4'd3, rd);
        chk(rd == 16'h00C5, "R10", "control readback", rd, 16'h00C5);

        // trigger during a running cycle is ignored
        for (int i = 0; i < 8; i++) set_slot(i, {5'b0, 3'(i)});
        set_slot(0, 8'b1000_0000);
        clear_mon();
        pulse_trig(t);
        pulse_trig(t);
        repeat (40) @(negedge clk);
        #1;
        chk(dones == 1, "R9", "busy trigger cycles", dones, 1);
        chk(starts == 1, "R9", "busy trigger starts", starts, 1);

        // continuous operation
        set_slot(1, 8'b1010_1001);
        clear_mon();
        @(negedge clk); #1;
        run_cont = 1'b1;
        wait_dones(2);
        run_cont = 1'b0;
        chk(gap == 1, "R9", "restart gap", gap, 1);
        chk(starts == 4, "R9", "continuous starts", starts, 4);
        chk(valids == 2, "R8", "one current valid per cycle", valids, 2);
        repeat (30) @(negedge clk);
        #1;
        chk(starts == 4, "R9", "no starts after stop", starts, 4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule